// File: doc/BRIEF.md
# PCI Target Read Termination Controller

This block runs the control side of a 32/64-bit PCI target while it serves a memory read. The read may be one data phase or a burst. The block claims the transaction when an address decoder flags a hit on the first clock of FRAME# assertion. It then paces TRDY# from a local-side ready signal and watches FRAME#, IRDY# and its own TRDY# to find the last data phase. It closes the transaction in two steps. First it drives DEVSEL#, TRDY#, STOP# and ACK64# high for one clock. Then it releases them to high impedance for the turnaround. Every bus line is modelled as a registered value plus a registered output enable.

On the local side, an active-low frame indication tells the local logic whether more data is wanted. A 12-bit status vector reports activity. Bit 10 is the per-phase transfer flag that local logic decodes. The block also enforces the target latency rules. If the local side does not supply data within the limit, the block ends the transaction with STOP#. The local side may also ask for a disconnect at any time during the data phases.

The controller is a four-state machine:
- IDLE: all lines released.
- XFER: data phases running.
- HALT: STOP# asserted, waiting for the master to drop FRAME#.
- DRIVE_HI: the single clock of sustained high drive.

Its transitions are:
- IDLE to XFER on a claimed address phase.
- XFER to DRIVE_HI on the final data transfer.
- XFER to HALT on a local disconnect request or on latency expiry.
- HALT to DRIVE_HI when FRAME# is sampled high.
- DRIVE_HI to IDLE always.

Top module: `pci_tgt_term_ctrl`

## Requirements
- R1: While reset is low, all five output enables are 0, every control value is 1, `loc_frame_n` is 1 and `loc_stat` is all zero. This also holds when reset is applied in the middle of a transaction.
- R2: A claim happens on an edge where `frame_n` is 0, `frame_n` was 1 at the previous edge, and `hit` is 1. In the next clock, DEVSEL# is driven low, TRDY# and STOP# are driven high, `ad_oe` is 1 and `loc_frame_n` is 0. In `loc_stat`, bit 11 (active) is 1 and bit 8 (wide) is 1 exactly when `req64_n` was 0 at that edge.
- R3: During the data phases, TRDY# is driven low in the clock after an edge where `loc_rdy` is 1. Once TRDY# is low, it stays low until an edge where IRDY# is also low.
- R4: `loc_stat[10]` is 1 in exactly the clocks that follow an edge where TRDY# was driven low and `irdy_n` was 0. It is 0 in all other clocks.
- R5: A final transfer is an edge where `frame_n` is 1 and a transfer occurs. In the clock after it, DEVSEL#, TRDY# and STOP# are driven high with their enables at 1, ACK64# is driven high if the transaction was claimed wide, `ad_oe` is 0, `loc_frame_n` is 1 and `loc_stat[10]` is 1.
- R6: In the clock after the high-drive clock, every control enable is 0 and `loc_stat` is all zero.
- R7: Count the claim clock as clock 0. If no data is supplied, STOP# is driven low from clock INIT_LIM onward. In that clock, TRDY# is high and DEVSEL# stays low.
- R8: After a transfer clock, if no further data is supplied, STOP# is driven low in the SUBS_LIM-th clock after the transfer clock.
- R9: An edge in the data phases where `loc_disc` is 1 and there is no final transfer gives STOP# low, TRDY# high and DEVSEL# low in the next clock. `loc_stat[9]` (terminated) is 1 in that clock.
- R10: STOP# stays low while `frame_n` is sampled 0. After the edge where `frame_n` is sampled 1, the R5 high-drive clock follows with `loc_stat[10]` at 0 and `loc_stat[9]` at 1, and then the R6 release.
- R11: No claim happens when `hit` is 0, or when `frame_n` was already 0 at the previous edge. In either case every enable stays 0.
- R12: When the claim saw `req64_n` at 1, `ack64_oe` stays 0 for the whole transaction. Bits 7 to 0 of `loc_stat` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Sampled FRAME# |
| irdy_n | input | 1 | Sampled IRDY# |
| req64_n | input | 1 | Sampled REQ64# |
| hit | input | 1 | Address decoder match, valid in the address phase |
| loc_rdy | input | 1 | Local side has read data for the next phase |
| loc_disc | input | 1 | Local side asks for a disconnect |
| devsel_n_o | output | 1 | DEVSEL# output value |
| devsel_oe | output | 1 | DEVSEL# output enable |
| trdy_n_o | output | 1 | TRDY# output value |
| trdy_oe | output | 1 | TRDY# output enable |
| stop_n_o | output | 1 | STOP# output value |
| stop_oe | output | 1 | STOP# output enable |
| ack64_n_o | output | 1 | ACK64# output value |
| ack64_oe | output | 1 | ACK64# output enable |
| ad_oe | output | 1 | AD bus output enable |
| loc_frame_n | output | 1 | Local frame indication, low while data is wanted |
| loc_stat | output | 12 | Status: bit 11 active, bit 10 transfer done, bit 9 terminated, bit 8 wide |

## Verification
The bench builds the block with its default limits of 16 clocks for the first phase and 8 for later phases. These are the bus values, so the expiry tests measure the real deadlines clock by clock rather than scaled-down ones. Both limits are short, which lets the bench wait out a full first-phase and a full later-phase timeout in a few dozen cycles. It can still observe the HALT hold and the complete release sequence that follows.

// File: rtl/tgt_term_pkg.sv
package tgt_term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_XFER     = 2'd1,
        ST_HALT     = 2'd2,
        ST_DRIVE_HI = 2'd3
    } tgt_state_e;

    // control line slots in the value / enable vectors
    localparam int LN_DEVSEL = 0;
    localparam int LN_TRDY   = 1;
    localparam int LN_STOP   = 2;
    localparam int LN_ACK64  = 3;
    localparam int N_LINES   = 4;

    // local status vector layout
    localparam int STAT_W      = 12;
    localparam int SB_ACTIVE   = 11;
    localparam int SB_XDONE    = 10;
    localparam int SB_TERM     = 9;
    localparam int SB_WIDE     = 8;

endpackage

// File: rtl/tgt_lat_timer.sv
module tgt_lat_timer #(
    parameter int INIT_LIM = 16,
    parameter int SUBS_LIM = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic xfer,
    input  logic run,
    output logic expire
);
    localparam int MAXL = (INIT_LIM > SUBS_LIM) ? INIT_LIM : SUBS_LIM;
    localparam int CW   = $clog2(MAXL + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] goal;
    logic          first_q;

    assign goal   = first_q ? CW'(INIT_LIM - 2) : CW'(SUBS_LIM - 2);
    assign expire = run && (cnt_q == goal);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else if (start) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else if (xfer) begin
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else if (run && cnt_q != CW'(MAXL)) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R8
    restart_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !start) |=> (cnt_q == '0 && !first_q));

endmodule

// File: rtl/tgt_ctl_reg.sv
module tgt_ctl_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] val_d,
    input  logic [N-1:0] oe_d,
    output logic [N-1:0] val_q,
    output logic [N-1:0] oe_q
);
    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q[i] <= 1'b1;
                oe_q[i]  <= 1'b0;
            end else begin
                val_q[i] <= val_d[i];
                oe_q[i]  <= oe_d[i];
            end
        end
    end

endmodule

// File: rtl/pci_tgt_term_ctrl.sv
module pci_tgt_term_ctrl
    import tgt_term_pkg::*;
#(
    parameter int INIT_LIM = 16,
    parameter int SUBS_LIM = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              req64_n,
    input  logic              hit,
    input  logic              loc_rdy,
    input  logic              loc_disc,
    output logic              devsel_n_o,
    output logic              devsel_oe,
    output logic              trdy_n_o,
    output logic              trdy_oe,
    output logic              stop_n_o,
    output logic              stop_oe,
    output logic              ack64_n_o,
    output logic              ack64_oe,
    output logic              ad_oe,
    output logic              loc_frame_n,
    output logic [STAT_W-1:0] loc_stat
);
    tgt_state_e         state_q, state_d;
    logic               frame_q;
    logic               wide_q, wide_d;
    logic [N_LINES-1:0] val_d, oe_d, val_q, oe_q;
    logic               ad_oe_d, lf_d;
    logic [STAT_W-1:0]  stat_d;
    logic               expire, xfer, last, addr_ph, term, run;

    assign devsel_n_o = val_q[LN_DEVSEL];
    assign devsel_oe  = oe_q[LN_DEVSEL];
    assign trdy_n_o   = val_q[LN_TRDY];
    assign trdy_oe    = oe_q[LN_TRDY];
    assign stop_n_o   = val_q[LN_STOP];
    assign stop_oe    = oe_q[LN_STOP];
    assign ack64_n_o  = val_q[LN_ACK64];
    assign ack64_oe   = oe_q[LN_ACK64];

    assign xfer    = (state_q == ST_XFER) && !trdy_n_o && !irdy_n;
    assign last    = xfer && frame_n;
    assign addr_ph = (state_q == ST_IDLE) && !frame_n && frame_q && hit;
    assign run     = (state_q == ST_XFER) && trdy_n_o;
    assign term    = loc_disc || (expire && !loc_rdy);
    assign wide_d  = addr_ph ? !req64_n : wide_q;

    tgt_lat_timer #(.INIT_LIM(INIT_LIM), .SUBS_LIM(SUBS_LIM)) i_timer (
        .clk(clk), .rst_n(rst_n), .start(addr_ph), .xfer(xfer),
        .run(run), .expire(expire)
    );

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (addr_ph) state_d = ST_XFER;
            ST_XFER:     if (last) state_d = ST_DRIVE_HI;
                         else if (term) state_d = ST_HALT;
            ST_HALT:     if (frame_n) state_d = ST_DRIVE_HI;
            ST_DRIVE_HI: state_d = ST_IDLE;
        endcase
    end

    // output process: registered outputs decoded from the next state
    always_comb begin
        val_d   = '1;
        oe_d    = '0;
        ad_oe_d = 1'b0;
        lf_d    = 1'b1;
        stat_d  = '0;
        unique case (state_d)
            ST_IDLE: begin
            end
            ST_XFER: begin
                oe_d               = {wide_d, 3'b111};
                val_d[LN_DEVSEL]   = 1'b0;
                val_d[LN_TRDY]     = !(loc_rdy ||
                                       ((state_q == ST_XFER) && !trdy_n_o && !xfer));
                val_d[LN_ACK64]    = !wide_d;
                ad_oe_d            = 1'b1;
                lf_d               = 1'b0;
            end
            ST_HALT: begin
                oe_d               = {wide_d, 3'b111};
                val_d[LN_DEVSEL]   = 1'b0;
                val_d[LN_STOP]     = 1'b0;
                val_d[LN_ACK64]    = !wide_d;
                ad_oe_d            = 1'b1;
                lf_d               = 1'b0;
            end
            ST_DRIVE_HI: begin
                oe_d               = {wide_d, 3'b111};
            end
        endcase
        if (state_d != ST_IDLE) begin
            stat_d[SB_ACTIVE] = 1'b1;
            stat_d[SB_XDONE]  = xfer;
            stat_d[SB_TERM]   = (state_d == ST_HALT) ||
                                ((state_d == ST_DRIVE_HI) && (state_q == ST_HALT));
            stat_d[SB_WIDE]   = wide_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            frame_q <= 1'b1;
            wide_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            frame_q <= frame_n;
            wide_q  <= wide_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ad_oe       <= 1'b0;
            loc_frame_n <= 1'b1;
            loc_stat    <= '0;
        end else begin
            ad_oe       <= ad_oe_d;
            loc_frame_n <= lf_d;
            loc_stat    <= stat_d;
        end
    end

    tgt_ctl_reg #(.N(N_LINES)) i_ctl (
        .clk(clk), .rst_n(rst_n), .val_d(val_d), .oe_d(oe_d),
        .val_q(val_q), .oe_q(oe_q)
    );

    // R4
    xdone_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_oe && !trdy_n_o && !irdy_n) |=> loc_stat[SB_XDONE]);
    // R4
    xdone_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(trdy_oe && !trdy_n_o && !irdy_n) |=> !loc_stat[SB_XDONE]);
    // R5
    drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_oe && !trdy_n_o && !irdy_n && frame_n) |=>
        (devsel_oe && devsel_n_o && trdy_oe && trdy_n_o && stop_oe && stop_n_o
         && !ad_oe && loc_frame_n));
    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE_HI) |=>
        (!devsel_oe && !trdy_oe && !stop_oe && !ack64_oe && loc_stat == '0));
    // R9
    disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_XFER) && loc_disc && !last) |=>
        (!stop_n_o && trdy_n_o && !devsel_n_o && loc_stat[SB_TERM]));
    // R7
    expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_XFER) && expire && !loc_rdy) |=> (!stop_n_o && trdy_n_o));
    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_oe && !stop_n_o && !frame_n) |=> (stop_oe && !stop_n_o));
    // R12
    low_stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_stat[7:0] == '0);

endmodule

// File: tb/test_pci_tgt_term_ctrl.sv
module test_pci_tgt_term_ctrl;
    localparam int CLK_NS   = 10;
    localparam int INIT_LIM = 16;
    localparam int SUBS_LIM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1, irdy_n = 1'b1, req64_n = 1'b1, hit = 1'b0;
    logic loc_rdy = 1'b0, loc_disc = 1'b0;
    logic devsel_n_o, devsel_oe, trdy_n_o, trdy_oe, stop_n_o, stop_oe;
    logic ack64_n_o, ack64_oe, ad_oe, loc_frame_n;
    logic [11:0] loc_stat;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    pci_tgt_term_ctrl #(.INIT_LIM(INIT_LIM), .SUBS_LIM(SUBS_LIM)) i_pci_tgt_term_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .req64_n(req64_n), .hit(hit), .loc_rdy(loc_rdy), .loc_disc(loc_disc),
        .devsel_n_o(devsel_n_o), .devsel_oe(devsel_oe), .trdy_n_o(trdy_n_o),
        .trdy_oe(trdy_oe), .stop_n_o(stop_n_o), .stop_oe(stop_oe),
        .ack64_n_o(ack64_n_o), .ack64_oe(ack64_oe), .ad_oe(ad_oe),
        .loc_frame_n(loc_frame_n), .loc_stat(loc_stat)
    );

    // obs = {dev_n, dev_oe, trdy_n, trdy_oe, stop_n, stop_oe, ack_n, ack_oe, ad_oe, lf_n, stat[11:8]}
    localparam logic [13:0] O_IDLE   = 14'b10_10_10_10_0_1_0000;
    localparam logic [13:0] O_HI_N_T = 14'b11_11_11_10_0_1_1010;

    typedef struct packed {
        logic [3:0]  rq;
        logic [5:0]  stim;   // {frame_n, irdy_n, req64_n, hit, loc_rdy, loc_disc}
        logic [13:0] exp;
    } row_t;

    localparam row_t TBL [14] = '{
        '{4'd1,  6'b1_1_1_0_0_0, 14'b10_10_10_10_0_1_0000},  // R1 idle
        '{4'd2,  6'b0_1_0_1_0_0, 14'b01_11_11_01_1_0_1001},  // R2 wide claim
        '{4'd3,  6'b0_0_1_0_1_0, 14'b01_01_11_01_1_0_1001},  // R3 trdy low
        '{4'd4,  6'b0_0_1_0_1_0, 14'b01_01_11_01_1_0_1101},  // R4 transfer flag
        '{4'd5,  6'b1_0_1_0_1_0, 14'b11_11_11_11_0_1_1101},  // R5 drive high
        '{4'd6,  6'b1_1_1_0_0_0, 14'b10_10_10_10_0_1_0000},  // R6 release
        '{4'd12, 6'b0_0_1_1_0_0, 14'b01_11_11_10_1_0_1000},  // R12 narrow claim
        '{4'd9,  6'b0_0_1_0_0_1, 14'b01_11_01_10_1_0_1010},  // R9 disconnect
        '{4'd10, 6'b0_0_1_0_0_0, 14'b01_11_01_10_1_0_1010},  // R10 hold
        '{4'd10, 6'b1_0_1_0_0_0, 14'b11_11_11_10_0_1_1010},  // R10 drive high
        '{4'd6,  6'b1_1_1_0_0_0, 14'b10_10_10_10_0_1_0000},  // R6 release
        '{4'd11, 6'b0_1_1_0_0_0, 14'b10_10_10_10_0_1_0000},  // R11 no hit
        '{4'd11, 6'b0_1_1_1_0_0, 14'b10_10_10_10_0_1_0000},  // R11 late hit
        '{4'd11, 6'b1_1_1_0_0_0, 14'b10_10_10_10_0_1_0000}   // R11 idle
    };

    function automatic logic [13:0] obs();
        return {devsel_n_o, devsel_oe, trdy_n_o, trdy_oe, stop_n_o, stop_oe,
                ack64_n_o, ack64_oe, ad_oe, loc_frame_n, loc_stat[11:8]};
    endfunction

    task automatic chk(input string tag, input logic [21:0] act, input logic [21:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [5:0] s);
        {frame_n, irdy_n, req64_n, hit, loc_rdy, loc_disc} = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        // R1 reset state
        @(negedge clk);
        chk("R1 reset outputs", 22'(obs()), 22'(O_IDLE));
        chk("R1 reset status", 22'(loc_stat), 22'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 14; i++) begin
            step(TBL[i].stim);
            chk($sformatf("R%0d table row %0d", TBL[i].rq, i), 22'(obs()), 22'(TBL[i].exp));
        end

        // R7 first-phase latency expiry
        step(6'b0_1_1_1_0_0);
        n = 1;
        while (stop_n_o && n < 40) begin
            step(6'b0_0_1_0_0_0);
            n++;
        end
        chk("R7 stop clock", 22'(n), 22'(INIT_LIM));
        chk("R7 trdy high devsel low", 22'({trdy_n_o, devsel_n_o, stop_oe}), 22'b101);
        step(6'b0_0_1_0_0_0);
        step(6'b0_0_1_0_0_0);
        chk("R10 stop held", 22'({stop_n_o, stop_oe}), 22'b01);
        step(6'b1_0_1_0_0_0);
        chk("R10 drive high after stop", 22'(obs()), 22'(O_HI_N_T));
        step(6'b1_1_1_0_0_0);
        chk("R6 release after stop", 22'(obs()), 22'(O_IDLE));

        // R8 later-phase latency expiry
        step(6'b0_1_1_1_0_0);
        step(6'b0_0_1_0_1_0);
        chk("R3 trdy low on data", 22'({trdy_n_o, trdy_oe}), 22'b01);
        n = 0;
        do begin
            step(6'b0_0_1_0_0_0);
            n++;
            if (n == 1) chk("R4 flag after transfer", 22'(loc_stat[10]), 22'd1);
        end while (stop_n_o && n < 40);
        chk("R8 stop clock", 22'(n), 22'(SUBS_LIM));
        step(6'b1_0_1_0_0_0);
        step(6'b1_1_1_0_0_0);
        chk("R6 release after R8", 22'(obs()), 22'(O_IDLE));

        // R3 trdy held while master waits
        step(6'b0_1_1_1_0_0);
        step(6'b0_1_1_0_1_0);
        step(6'b0_1_1_0_0_0);
        chk("R3 trdy held", 22'({trdy_n_o, loc_stat[10]}), 22'b00);
        step(6'b1_0_1_0_0_0);
        chk("R5 final after wait", 22'({devsel_n_o, trdy_n_o, stop_n_o, ad_oe, loc_stat[10]}), 22'b11101);
        step(6'b1_1_1_0_0_0);

        // R1 reset mid-transaction
        step(6'b0_1_0_1_0_0);
        rst_n = 1'b0;
        #1;
        chk("R1 mid reset", 22'({obs(), loc_stat[7:0]}), 22'({O_IDLE, 8'd0}));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule